// File: doc/BRIEF.md
# Bus-Matching Width Narrower with Selectable Piece Order

This block sits on the read side of a wide data buffer. It takes one long word at a time from the write side and hands it downstream as a series of narrower pieces. The long word is 36 bits, made of four 9-bit lanes. Each lane keeps its own ninth bit as a parity position, so the lanes are bits [8:0], [17:9], [26:18] and [35:27]. The block can send those four lanes one at a time, or send the word as two 18-bit halves.

Two configuration inputs set how the block works. One picks the piece width and the other picks whether the most or the least significant piece goes first. Both are sampled only while master reset is held high, and both stay fixed until the next reset. Both sides use a valid/ready handshake. The block holds the current long word until downstream has taken its last piece, and only then accepts the next word.

Top module: `bus_narrower`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1.
- R2: With `cfg_half`=0 latched, each accepted 36-bit word produces exactly four pieces. Each piece is one 9-bit lane placed on `out_data[8:0]`, and `out_data[17:9]` reads 0.
- R3: With `cfg_half`=1 latched, each accepted word produces exactly two pieces: bits [17:0] and bits [35:18] on `out_data[17:0]`.
- R4: With `cfg_big`=1 latched, pieces come out from the most significant position down to the least significant.
- R5: With `cfg_big`=0 latched, pieces come out from the least significant position up to the most significant.
- R6: `cfg_half` and `cfg_big` are captured on every clock edge where `rst` is high. Changing them while `rst` is low has no effect on width or order.
- R7: `in_ready` is 0 from the edge that accepts a word until the edge where its last piece is accepted. It is 1 in the cycle right after that edge, and a word offered meanwhile is not taken.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R9: A master reset in the middle of a word discards the pieces still pending. The next word starts again from its first piece.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous master reset, active high; configuration is sampled while high |
| cfg_half | input | 1 | Piece width: 1 = 18-bit halves, 0 = 9-bit lanes |
| cfg_big | input | 1 | Piece order: 1 = most significant first, 0 = least significant first |
| in_data | input | 36 | Long word from the write side |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Block can take a long word |
| out_data | output | 18 | Current piece; 9-bit pieces sit in bits [8:0] |
| out_valid | output | 1 | `out_data` holds a piece |
| out_ready | input | 1 | Downstream takes the piece |

## Verification
The bench runs all four combinations of width and order. Every lane holds a distinct value, so a reversed or shifted lane index shows up as a data mismatch, and so does a piece count that treats 9-bit mode as two pieces. It changes both configuration inputs after reset, which catches a design that samples them live and so flips width or order partway through. It holds `out_ready` low to catch a design that advances or drops a piece under backpressure. It keeps `in_valid` high while a word is still pending, which exposes a design that overwrites the held word. It also resets in the middle of a word, which catches a piece counter that survives reset and starts the next word at the wrong lane.

// File: rtl/bus_narrower.sv
module bus_narrower #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_half,
  input  logic                    cfg_big,
  input  logic [LANE_W*LANES-1:0] in_data,
  input  logic                    in_valid,
  output logic                    in_ready,
  output logic [2*LANE_W-1:0]     out_data,
  output logic                    out_valid,
  input  logic                    out_ready
);
  localparam int WIDE_W = LANE_W * LANES;
  localparam int HALF_W = 2 * LANE_W;
  localparam int CNT_W  = (LANES > 1) ? $clog2(LANES) : 1;

  logic [WIDE_W-1:0] word_q;
  logic              full_q, half_q, big_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last_idx, pos;
  logic              last_w;
  logic [HALF_W-1:0] piece;

  assign last_idx  = half_q ? CNT_W'(LANES/2 - 1) : CNT_W'(LANES - 1);
  assign last_w    = (cnt_q == last_idx);
  assign pos       = big_q ? last_idx - cnt_q : cnt_q;
  assign in_ready  = !full_q;
  assign out_valid = full_q;
  assign out_data  = piece;

  always_comb begin
    piece = '0;
    if (half_q) piece = word_q[int'(pos)*HALF_W +: HALF_W];
    else        piece[LANE_W-1:0] = word_q[int'(pos)*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      cnt_q  <= '0;
      word_q <= '0;
      half_q <= cfg_half;
      big_q  <= cfg_big;
    end else if (in_valid && in_ready) begin
      word_q <= in_data;
      full_q <= 1'b1;
      cnt_q  <= '0;
    end else if (out_valid && out_ready) begin
      if (last_w) begin
        full_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

module bus_narrower_chk #(
  parameter int LANE_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [2*LANE_W-1:0] out_data,
  input logic              half_q,
  input logic              big_q,
  input logic              last_w
);
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready)); // R1
  AST_LANE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !half_q) |-> (out_data[2*LANE_W-1:LANE_W] == '0)); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(half_q) && $stable(big_q))); // R6
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R7
  AST_LAST_FREES: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && last_w) |=> in_ready); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
endmodule

bind bus_narrower bus_narrower_chk #(.LANE_W(LANE_W)) chk_i (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .half_q(half_q),
  .big_q(big_q), .last_w(last_w)
);

// File: tb/bus_narrower_tb.sv
module bus_narrower_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_half = 1'b0, cfg_big = 1'b0;
  logic [35:0] in_data = '0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic        in_ready, out_valid;
  logic [17:0] out_data;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  bus_narrower dut_i (.*);

  // {half, big, word}
  localparam logic [37:0] VEC [6] = '{
    {1'b0, 1'b1, 36'h1_2345_6789},
    {1'b0, 1'b0, 36'h1_2345_6789},
    {1'b1, 1'b1, 36'hA_BCDE_F012},
    {1'b1, 1'b0, 36'hA_BCDE_F012},
    {1'b0, 1'b1, 36'hF_00FF_1E2D},
    {1'b1, 1'b0, 36'h5_A5A5_0F0F}
  };

  function automatic logic [17:0] exp_piece(logic [35:0] w, bit h, bit b, int k);
    int n   = h ? 2 : 4;
    int idx = b ? n - 1 - k : k;
    if (h) return w[idx*18 +: 18];
    return {9'b0, w[idx*9 +: 9]};
  endfunction

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(bit h, bit b);
    @(negedge clk);
    rst = 1'b1; cfg_half = h; cfg_big = b; in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(logic [35:0] w);
    in_valid = 1'b1; in_data = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(logic [35:0] w, bit h, bit b, string req);
    out_ready = 1'b1;
    for (int k = 0; k < (h ? 2 : 4); k++) begin
      chk({req, " valid"}, 36'(out_valid), 36'd1);
      chk({req, " piece"}, 36'(out_data), 36'(exp_piece(w, h, b, k)));
      chk("R7 busy", 36'(in_ready), 36'd0);
      @(negedge clk);
    end
    chk("R7 freed", 36'(in_ready), 36'd1);
    chk({req, " count"}, 36'(out_valid), 36'd0);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset(1'b0, 1'b0);
    chk("R1 out_valid", 36'(out_valid), 36'd0);
    chk("R1 in_ready", 36'(in_ready), 36'd1);

    // table walk: R2/R3 width, R4/R5 order
    foreach (VEC[i]) begin
      do_reset(VEC[i][37], VEC[i][36]);
      send(VEC[i][35:0]);
      drain(VEC[i][35:0], VEC[i][37], VEC[i][36],
            VEC[i][37] ? (VEC[i][36] ? "R3 R4" : "R3 R5")
                       : (VEC[i][36] ? "R2 R4" : "R2 R5"));
    end

    // R6: config changes outside reset ignored
    do_reset(1'b0, 1'b0);
    cfg_half = 1'b1; cfg_big = 1'b1;
    @(negedge clk);
    send(36'h9_8765_4321);
    drain(36'h9_8765_4321, 1'b0, 1'b0, "R6");

    // R8: backpressure holds piece; R7: offered word meanwhile not taken
    do_reset(1'b1, 1'b1);
    send(36'h3_3333_CCCC);
    in_valid = 1'b1; in_data = 36'h0_0000_0001;
    repeat (3) begin
      chk("R8 valid held", 36'(out_valid), 36'd1);
      chk("R8 data held", 36'(out_data), 36'(exp_piece(36'h3_3333_CCCC, 1'b1, 1'b1, 0)));
      @(negedge clk);
    end
    in_valid = 1'b0;
    drain(36'h3_3333_CCCC, 1'b1, 1'b1, "R7 R8");

    // R9: reset mid-word restarts at first piece
    do_reset(1'b0, 1'b1);
    send(36'h1_1122_3344);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    do_reset(1'b0, 1'b1);
    chk("R9 dropped", 36'(out_valid), 36'd0);
    send(36'h7_6655_4433);
    drain(36'h7_6655_4433, 1'b0, 1'b1, "R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule